// File: doc/BRIEF.md
# Bay Control Register Block with Power and State Interlocks

This block holds one 8-bit control word per drive bay behind a simple memory-mapped register bus. Each control word carries a lock bit, a requested bay state, three enables and a power-control bit. Software writes the word through a single-cycle write strobe. Reads are combinational and return the word of the addressed bay in the same cycle.

Hardware gates software's writes against the bay's device presence. Each bay has two active-low presence inputs, and a device counts as present when either input is low. A requested-state write takes effect only while a device is present, and only when it carries a defined, nonzero code. The power bit can be set only when two conditions hold together: a device is present, and the lock value written in that same word is 1. While a bay is empty, hardware holds both its state field and its power bit at zero, which clears them on removal. The block drives the lock, state, enables and power-enable outputs straight from the stored fields.

Top module: `bay_ctl_regs`

## Requirements
- R1: After the asynchronous active-low reset, every control word is zero, all outputs are low and every read returns 0.
- R2: Bay 0 is at address 0x10 and bay 1 at 0x18. Any other address reads 0 and a write to it changes nothing. Read bits 31:8 are always 0, and write bits 31:8 are ignored.
- R3: The word layout is bit 7 lock, bits 6:4 requested state, bit 3 removal-request enable, bit 2 status-change enable, bit 1 removal-wake enable and bit 0 power. State codes 1 (inserted), 2 (enabled), 3 (removal requested) and 4 (removal allowed) are stored when written while a device is present.
- R4: Writing state code 0 leaves the stored state unchanged, while the other fields of the same write still take effect.
- R5: Writing a reserved state code (5, 6 or 7) leaves the stored state unchanged, so the stored state is never above 4.
- R6: A bay is present when either of its two active-low presence inputs is low. A state write to an empty bay has no effect.
- R7: While a bay is empty, its state field and power bit are cleared at the next clock edge. A device removed while powered therefore loses power and state one cycle later, and the lock and enables are kept.
- R8: The power bit becomes 1 only on a write with bit 0 set, bit 7 set and the device present. Such a single write may set lock and power together. Any other write leaves power at 0.
- R9: The outputs lock, requested state, the three enables and power-enable mirror the stored fields of each bay in every cycle.
- R10: The lock and the three enable bits are written from every write to the bay, whether or not a device is present. Without a write, the whole word holds while the device stays present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Word address |
| wr_en_i | input | 1 | Write strobe, one word per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed bay, combinational |
| prsnt_a_ni | input | 2 | First presence input per bay, active low |
| prsnt_b_ni | input | 2 | Second presence input per bay, active low |
| lock_o | output | 2 | Lock bit per bay |
| req_state_o | output | 6 | Requested state, 3 bits per bay, bay 0 in bits 2:0 |
| remreq_en_o | output | 2 | Removal-request enable per bay |
| stchg_en_o | output | 2 | Status-change enable per bay |
| wake_en_o | output | 2 | Removal-wake enable per bay |
| pwr_en_o | output | 2 | Power enable per bay |

## Verification
The bench sets lock and power in one word. A design that judged the interlock against the old lock value would refuse that power request. The bench also clears lock while requesting power, and a design that got this wrong would leave power on with the lock open. It writes codes 0 and 5 to see that the state is kept; a design that stored these codes blindly would lose the requested state or hold an undefined one. It pulls a device out while power is on and then writes state to the empty bay. A missing clear would keep the bay powered, and missing gating would record a state for an empty bay. Unmapped addresses, set upper write bits and random traffic against a cycle model expose decode aliasing and cross-bay corruption.

// File: rtl/bay_ctl_pkg.sv
package bay_ctl_pkg;

  typedef enum logic [2:0] {
    ST_NONE     = 3'd0,
    ST_INSERTED = 3'd1,
    ST_ENABLED  = 3'd2,
    ST_REM_REQ  = 3'd3,
    ST_REM_OK   = 3'd4
  } bay_state_e;

  localparam int unsigned CTL_W  = 8;
  localparam int unsigned BUS_W  = 32;
  localparam logic [2:0] ST_MAX  = ST_REM_OK;

  // bit 7 down to bit 0
  typedef struct packed {
    logic       lock;
    logic [2:0] state;
    logic       remreq_en;
    logic       stchg_en;
    logic       wake_en;
    logic       pwr;
  } bay_ctl_t;

  function automatic logic state_code_ok(logic [2:0] code);
    return (code != ST_NONE) && (code <= ST_MAX);
  endfunction

endpackage

// File: rtl/bay_addr_dec.sv
module bay_addr_dec #(
  parameter int unsigned NUM_BAYS  = 2,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h10,
  parameter int unsigned STRIDE    = 'h8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_BAYS-1:0] sel_o
);

  for (genvar i = 0; i < NUM_BAYS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] BayAddr = ADDR_W'(BASE_ADDR + i * STRIDE);
    assign sel_o[i] = (addr_i == BayAddr);
  end

endmodule

// File: rtl/bay_presence.sv
module bay_presence (
  input  logic prsnt_a_ni,
  input  logic prsnt_b_ni,
  output logic present_o
);

  // either detect line pulled low means a device sits in the bay
  assign present_o = ~prsnt_a_ni | ~prsnt_b_ni;

endmodule

// File: rtl/bay_ctl_reg.sv
module bay_ctl_reg
  import bay_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             present_i,
  output bay_ctl_t         ctl_o
);

  bay_ctl_t ctl_q, ctl_d, wr_w;

  assign wr_w = bay_ctl_t'(wdata_i);

  always_comb begin
    ctl_d = ctl_q;
    if (we_i) begin
      ctl_d.lock      = wr_w.lock;
      ctl_d.remreq_en = wr_w.remreq_en;
      ctl_d.stchg_en  = wr_w.stchg_en;
      ctl_d.wake_en   = wr_w.wake_en;
      // interlock judged against the lock value in this same write
      ctl_d.pwr       = wr_w.pwr & wr_w.lock & present_i;
      if (present_i && state_code_ok(wr_w.state)) ctl_d.state = wr_w.state;
    end
    if (!present_i) begin
      ctl_d.state = ST_NONE;
      ctl_d.pwr   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  assert_pwr_needs_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.pwr |-> ctl_q.lock);

  assert_empty_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_i |=> (ctl_q.state == ST_NONE) && !ctl_q.pwr);

  assert_state_legal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.state <= ST_MAX);

  assert_zero_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && present_i && wdata_i[6:4] == 3'd0) |=> $stable(ctl_q.state));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && present_i) |=> $stable(ctl_q));

endmodule

// File: rtl/bay_ctl_regs.sv
module bay_ctl_regs
  import bay_ctl_pkg::*;
#(
  parameter int unsigned NUM_BAYS  = 2,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'h10,
  parameter int unsigned STRIDE    = 'h8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_en_i,
  input  logic [BUS_W-1:0]      wdata_i,
  output logic [BUS_W-1:0]      rdata_o,
  input  logic [NUM_BAYS-1:0]   prsnt_a_ni,
  input  logic [NUM_BAYS-1:0]   prsnt_b_ni,
  output logic [NUM_BAYS-1:0]   lock_o,
  output logic [NUM_BAYS*3-1:0] req_state_o,
  output logic [NUM_BAYS-1:0]   remreq_en_o,
  output logic [NUM_BAYS-1:0]   stchg_en_o,
  output logic [NUM_BAYS-1:0]   wake_en_o,
  output logic [NUM_BAYS-1:0]   pwr_en_o
);

  localparam int unsigned PadW = BUS_W - CTL_W;

  logic [NUM_BAYS-1:0] sel;
  logic [NUM_BAYS-1:0] present;
  bay_ctl_t            ctl [NUM_BAYS];
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[BUS_W-1:CTL_W];

  bay_addr_dec #(
    .NUM_BAYS (NUM_BAYS),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .STRIDE   (STRIDE)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  for (genvar i = 0; i < NUM_BAYS; i++) begin : g_bay
    bay_presence u_prs (
      .prsnt_a_ni(prsnt_a_ni[i]),
      .prsnt_b_ni(prsnt_b_ni[i]),
      .present_o (present[i])
    );

    bay_ctl_reg u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (wr_en_i & sel[i]),
      .wdata_i  (wdata_i[CTL_W-1:0]),
      .present_i(present[i]),
      .ctl_o    (ctl[i])
    );

    assign lock_o[i]            = ctl[i].lock;
    assign req_state_o[i*3 +: 3] = ctl[i].state;
    assign remreq_en_o[i]       = ctl[i].remreq_en;
    assign stchg_en_o[i]        = ctl[i].stchg_en;
    assign wake_en_o[i]         = ctl[i].wake_en;
    assign pwr_en_o[i]          = ctl[i].pwr;

    // other bays' writes leave this word alone
    assert_bay_isolated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(wr_en_i && sel[i]) && present[i]) |=> $stable(pwr_en_o[i]) && $stable(lock_o[i]));
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_BAYS; i++) begin
      if (sel[i]) rdata_o = {{PadW{1'b0}}, ctl[i]};
    end
  end

endmodule

// File: tb/bay_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module bay_ctl_regs_tb_top;

  localparam int NB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NB-1:0] pa_n = '1, pb_n = '1;
  logic [NB-1:0] lock, remreq, stchg, wake, pwr;
  logic [NB*3-1:0] rstate;

  int total = 0, bad = 0;
  bit cmp_on = 0;
  logic [7:0] m [NB];

  always #5 clk = ~clk;

  bay_ctl_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .prsnt_a_ni(pa_n), .prsnt_b_ni(pb_n), .lock_o(lock),
    .req_state_o(rstate), .remreq_en_o(remreq), .stchg_en_o(stchg),
    .wake_en_o(wake), .pwr_en_o(pwr)
  );

  // behavioural reference of the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) m[i] <= 8'h00;
    end else begin
      for (int i = 0; i < NB; i++) begin
        logic [7:0] v;
        bit pres;
        v = m[i];
        pres = !pa_n[i] || !pb_n[i];
        if (wr && addr == 8'(8'h10 + 8 * i)) begin
          v[7] = wdata[7];
          v[3:1] = wdata[3:1];
          v[0] = wdata[0] && wdata[7] && pres;
          if (pres && wdata[6:4] >= 1 && wdata[6:4] <= 4) v[6:4] = wdata[6:4];
        end
        if (!pres) begin
          v[6:4] = 3'd0;
          v[0] = 1'b0;
        end
        m[i] <= v;
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    for (int i = 0; i < NB; i++)
      if (a == 8'(8'h10 + 8 * i)) return {24'h0, m[i]};
    return 32'h0;
  endfunction

  // per-cycle comparison of all outputs (R9) and read data (R2)
  always @(negedge clk) begin
    #2;
    if (cmp_on) begin
      for (int i = 0; i < NB; i++) begin
        logic [7:0] got;
        got = {lock[i], rstate[i*3 +: 3], remreq[i], stchg[i], wake[i], pwr[i]};
        total++;
        if (got !== m[i]) begin
          bad++;
          $display("FAIL R9 bay%0d outputs got=%h exp=%h", i, got, m[i]);
        end
      end
      total++;
      if (rdata !== exp_rd(addr)) begin
        bad++;
        $display("FAIL R2 read addr=%h got=%h exp=%h", addr, rdata, exp_rd(addr));
      end
    end
  end

  task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    wr = 1'b0; addr = a;
    #1;
    total++;
    if (rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk_bit(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    cmp_on = 1;
    chk_rd(8'h10, 32'h0, "R1 reset bay0");
    chk_rd(8'h18, 32'h0, "R1 reset bay1");
    chk_bit(pwr[0] | pwr[1] | lock[0] | lock[1], 1'b0, "R1 outputs low");

    // empty bay: state and power refused, lock/enables taken
    wr_word(8'h10, 32'h9F);
    chk_rd(8'h10, 32'h8E, "R6 R10 empty bay write");

    pb_n[0] = 1'b0;  // present through second line
    wr_word(8'h10, 32'h91);
    chk_rd(8'h10, 32'h91, "R8 R3 lock+power one write");
    chk_bit(pwr[0], 1'b1, "R9 pwr_en follows");

    wr_word(8'h10, 32'h0D);
    chk_rd(8'h10, 32'h1C, "R4 R8 zero state keeps, power refused lock clear");

    wr_word(8'h10, 32'hD1);
    chk_rd(8'h10, 32'h91, "R5 reserved code 5 kept");
    wr_word(8'h10, 32'hF1);
    chk_rd(8'h10, 32'h91, "R5 reserved code 7 kept");

    wr_word(8'h10, 32'hC1);
    chk_rd(8'h10, 32'hC1, "R3 removal allowed code");
    wr_word(8'h10, 32'h01);
    chk_rd(8'h10, 32'h40, "R8 power without lock refused");
    wr_word(8'h10, 32'hB1);
    chk_rd(8'h10, 32'hB1, "R3 removal requested code");

    pb_n[0] = 1'b1;  // device pulled out while powered
    @(negedge clk);
    chk_rd(8'h10, 32'h80, "R7 removal clears state and power");
    chk_bit(pwr[0], 1'b0, "R7 pwr_en dropped");

    pa_n[1] = 1'b0;  // bay1 present through first line
    wr_word(8'h18, 32'hA1);
    chk_rd(8'h18, 32'hA1, "R6 R3 bay1 enabled state");
    chk_rd(8'h10, 32'h80, "R2 bay0 untouched");

    wr_word(8'h14, 32'hFF);
    chk_rd(8'h14, 32'h0, "R2 unmapped reads zero");
    chk_rd(8'h18, 32'hA1, "R2 unmapped write ignored");

    wr_word(8'h18, 32'hFFFF_FFA1);
    chk_rd(8'h18, 32'hA1, "R2 upper bits zero");
    chk_bit(rstate[5:3] == 3'd2, 1'b1, "R9 state output bay1");
    chk_bit(lock[1], 1'b1, "R9 lock output bay1");

    wr_word(8'h10, 32'h0E);
    chk_rd(8'h10, 32'h0E, "R10 enables written while empty");

    repeat (4) @(negedge clk);
    chk_rd(8'h18, 32'hA1, "R10 idle hold");

    // random traffic against the model
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      addr = ($urandom % 4 == 0) ? 8'($urandom) : (($urandom % 2) ? 8'h10 : 8'h18);
      wdata = $urandom;
      wr = ($urandom % 2);
      if ($urandom % 8 == 0) pa_n = NB'($urandom);
      if ($urandom % 8 == 0) pb_n = NB'($urandom);
    end
    @(negedge clk);
    wr = 1'b0;

    rst_n = 1'b0;
    #1;
    chk_rd(8'h10, 32'h0, "R1 reset again bay0");
    chk_rd(8'h18, 32'h0, "R1 reset again bay1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule